// File: doc/BRIEF.md
# Indirect I/O Register Window

This block is a small slave that sits in a 32-byte I/O space. It lets a host reach a much larger memory-mapped register space through two 32-bit ports. The host first writes a register offset into the pointer port, and the block keeps that value. The host then reads or writes the data port. If the stored offset lies inside the register range, the block forwards the access to a downstream register bus and waits for that bus to answer.

Any other offset is rejected. The block sorts such offsets into three regions: undefined, flash and unknown. A rejected read returns zero and a rejected write is dropped. For every rejected data-port access, a one-cycle strobe with a 2-bit class code reports which region the offset fell in. All accesses are full 32-bit words.

Host handshake: the host raises `hostValid` with its fields and holds them until `hostReady` pulses for one cycle. On that pulse `hostRdata` carries the read result, and the host drops `hostValid` before the next clock edge.

Top module: `ioIndirectWindow`

## Requirements
- R1: After a synchronous reset, `hostReady`, `regReq` and `rejStrobe` are low, and the stored offset reads back as 0 through the pointer port.
- R2: A write to the pointer port (window offset 0x0) stores all 32 bits of `hostWdata`. A later read of the pointer port returns that value unchanged. Pointer-port accesses complete with `hostReady` one cycle after `hostValid` is first sampled.
- R3: A data-port access (window offset 0x4) with a stored offset strictly below 0x1FFFF raises `regReq`. It drives `regAddr` with the low 17 bits of the offset, `regWe` with the access direction and `regWdata` with the write data, and holds all of them until `regAck`.
- R4: During a forwarded access the host is stalled. `hostReady` rises in the cycle after `regAck` is sampled, and a read then returns `regRdata`. `regReq` is high for exactly as many cycles as the bus takes to answer.
- R5: A stored offset in [0x1FFFF, 0x7FFFF) is the undefined region. Data reads return 0, data writes issue no bus request, and the access completes in one cycle with class code 1.
- R6: A stored offset in [0x7FFFF, 0xFFFFF) is the flash region. It is rejected the same way as R5, with class code 2.
- R7: A stored offset of 0xFFFFF or more is the unknown region. It is rejected the same way as R5, with class code 3.
- R8: An access to any window offset other than 0x0 and 0x4 reads 0, leaves the stored offset unchanged, issues no bus request and raises no rejection strobe.
- R9: The range limits are exclusive at the top of the register region. Offset 0x1FFFE is forwarded, and offset 0x1FFFF is rejected as undefined.
- R10: `rejStrobe` is high for exactly one cycle per rejected data-port access, in the same cycle as `hostReady`, with `rejClass` valid.
- R11: A data-port access right after reset targets register address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostValid | input | 1 | Host access request, held until hostReady |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostOffset | input | 5 | Byte offset inside the 32-byte window |
| hostWdata | input | 32 | Host write data |
| hostReady | output | 1 | One-cycle completion pulse |
| hostRdata | output | 32 | Read result, valid with hostReady |
| regReq | output | 1 | Downstream request, held until regAck |
| regWe | output | 1 | Downstream write enable |
| regAddr | output | 17 | Downstream register byte address |
| regWdata | output | 32 | Downstream write data |
| regRdata | input | 32 | Downstream read data, valid with regAck |
| regAck | input | 1 | Downstream completion, one cycle |
| rejStrobe | output | 1 | Rejected data-port access marker |
| rejClass | output | 2 | 1 undefined, 2 flash, 3 unknown |

## Verification
The bench probes the offsets on each side of every region limit: 0x1FFFE against 0x1FFFF, 0x7FFFE against 0x7FFFF, 0xFFFFE against 0xFFFFF, and the all-ones offset. A comparator written with the wrong sense, `<=` in place of `<`, would forward 0x1FFFF or give the wrong class code at one of these points. Slow bus answers are also tested. A block that released the host early would return stale data or count the wrong number of request cycles. Accesses to the unused window offsets are followed by a read of the pointer port, so a decode that treated them as pointer writes would show a corrupted offset. A read issued straight after reset catches a stored offset that reset does not clear.

// File: rtl/ioWinPkg.sv
package ioWinPkg;

  // Region of the stored offset; REJ_NONE marks the forwardable register range
  typedef enum logic [1:0] {
    REJ_NONE    = 2'd0,
    REJ_UNDEF   = 2'd1,
    REJ_FLASH   = 2'd2,
    REJ_UNKNOWN = 2'd3
  } rejClassE;

  // Source of the host response register
  typedef enum logic [1:0] {
    RSP_ZERO   = 2'd0,
    RSP_OFFSET = 2'd1,
    RSP_REGBUS = 2'd2
  } rspSelE;

  // Control-to-datapath strobes
  typedef struct packed {
    logic   latchOff;
    logic   latchWdata;
    logic   rspLoad;
    rspSelE rspSel;
  } dpCtlS;

endpackage

// File: rtl/ioWinCtrl.sv
module ioWinCtrl
  import ioWinPkg::*;
#(
  parameter int                 DATA_W      = 32,
  parameter int                 WIN_AW      = 5,
  parameter int                 ADDR_PORT   = 0,
  parameter int                 DATA_PORT   = 4,
  parameter logic [DATA_W-1:0]  REG_LIMIT   = 'h1FFFF,
  parameter logic [DATA_W-1:0]  UNDEF_LIMIT = 'h7FFFF,
  parameter logic [DATA_W-1:0]  FLASH_LIMIT = 'hFFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [WIN_AW-1:0] hostOffset,
  input  logic [DATA_W-1:0] curOffset,
  input  logic              regAck,
  output dpCtlS             dpCtl,
  output logic              hostReady,
  output logic              regReq,
  output logic              regWe,
  output logic              rejStrobe,
  output rejClassE          rejClass
);

  localparam logic [WIN_AW-1:0] ADDR_SEL = ADDR_PORT[WIN_AW-1:0];
  localparam logic [WIN_AW-1:0] DATA_SEL = DATA_PORT[WIN_AW-1:0];

  typedef enum logic [1:0] {ST_IDLE, ST_FWD, ST_DONE} stateE;

  stateE    state, stateNext;
  rejClassE region;
  logic     isAddrPort, isDataPort, acceptFwd, acceptRej;

  assign isAddrPort = (hostOffset == ADDR_SEL);
  assign isDataPort = (hostOffset == DATA_SEL);

  // Region decode of the stored offset, upper limits exclusive
  always_comb begin
    if (curOffset < REG_LIMIT)        region = REJ_NONE;
    else if (curOffset < UNDEF_LIMIT) region = REJ_UNDEF;
    else if (curOffset < FLASH_LIMIT) region = REJ_FLASH;
    else                              region = REJ_UNKNOWN;
  end

  assign acceptFwd = (state == ST_IDLE) && hostValid && isDataPort && (region == REJ_NONE);
  assign acceptRej = (state == ST_IDLE) && hostValid && isDataPort && (region != REJ_NONE);

  always_comb begin
    stateNext = state;
    dpCtl     = '{latchOff: 1'b0, latchWdata: 1'b0, rspLoad: 1'b0, rspSel: RSP_ZERO};
    unique case (state)
      ST_IDLE: begin
        if (hostValid) begin
          if (acceptFwd) begin
            dpCtl.latchWdata = 1'b1;
            stateNext        = ST_FWD;
          end else begin
            dpCtl.rspLoad  = 1'b1;
            dpCtl.rspSel   = (isAddrPort && !hostWrite) ? RSP_OFFSET : RSP_ZERO;
            dpCtl.latchOff = isAddrPort && hostWrite;
            stateNext      = ST_DONE;
          end
        end
      end
      ST_FWD: begin
        if (regAck) begin
          dpCtl.rspLoad = 1'b1;
          dpCtl.rspSel  = RSP_REGBUS;
          stateNext     = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      regWe     <= 1'b0;
      rejStrobe <= 1'b0;
      rejClass  <= REJ_NONE;
    end else begin
      state     <= stateNext;
      rejStrobe <= acceptRej;
      if (acceptRej) rejClass <= region;
      if (acceptFwd) regWe    <= hostWrite;
    end
  end

  assign hostReady = (state == ST_DONE);
  assign regReq    = (state == ST_FWD);

  AST_REQ_HOLD:    assert property (@(posedge clk) disable iff (rst) (regReq && !regAck) |=> regReq); // R4
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst) (regReq && regAck) |=> (hostReady && !regReq)); // R4
  AST_STROBE_ONE:  assert property (@(posedge clk) disable iff (rst) rejStrobe |=> !rejStrobe); // R10
  AST_STROBE_RDY:  assert property (@(posedge clk) disable iff (rst) rejStrobe |-> (hostReady && rejClass != REJ_NONE)); // R10
  AST_REJ_NOREQ:   assert property (@(posedge clk) disable iff (rst) rejStrobe |-> !regReq); // R5
  AST_WE_HOLD:     assert property (@(posedge clk) disable iff (rst) (regReq && !regAck) |=> $stable(regWe)); // R3

endmodule

// File: rtl/ioWinData.sv
module ioWinData
  import ioWinPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtlS             dpCtl,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] curOffset,
  output logic [DATA_W-1:0] hostRdata,
  output logic [REG_AW-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata
);

  logic [DATA_W-1:0] offReg, rspReg, wdReg, rspNext;

  always_comb begin
    unique case (dpCtl.rspSel)
      RSP_OFFSET: rspNext = offReg;
      RSP_REGBUS: rspNext = regRdata;
      default:    rspNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      offReg <= '0;
      rspReg <= '0;
      wdReg  <= '0;
    end else begin
      if (dpCtl.latchOff)   offReg <= hostWdata;
      if (dpCtl.latchWdata) wdReg  <= hostWdata;
      if (dpCtl.rspLoad)    rspReg <= rspNext;
    end
  end

  assign curOffset = offReg;
  assign hostRdata = rspReg;
  assign regAddr   = offReg[REG_AW-1:0];
  assign regWdata  = wdReg;

  AST_OFF_LATCH: assert property (@(posedge clk) disable iff (rst) dpCtl.latchOff |=> (curOffset == $past(hostWdata))); // R2
  AST_OFF_KEEP:  assert property (@(posedge clk) disable iff (rst) !dpCtl.latchOff |=> $stable(curOffset)); // R8

endmodule

// File: rtl/ioIndirectWindow.sv
module ioIndirectWindow
  import ioWinPkg::*;
#(
  parameter int                 DATA_W      = 32,
  parameter int                 WIN_AW      = 5,
  parameter int                 REG_AW      = 17,
  parameter int                 ADDR_PORT   = 0,
  parameter int                 DATA_PORT   = 4,
  parameter logic [DATA_W-1:0]  REG_LIMIT   = 'h1FFFF,
  parameter logic [DATA_W-1:0]  UNDEF_LIMIT = 'h7FFFF,
  parameter logic [DATA_W-1:0]  FLASH_LIMIT = 'hFFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [WIN_AW-1:0] hostOffset,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostReady,
  output logic [DATA_W-1:0] hostRdata,
  output logic              regReq,
  output logic              regWe,
  output logic [REG_AW-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata,
  input  logic              regAck,
  output logic              rejStrobe,
  output logic [1:0]        rejClass
);

  dpCtlS             dpCtl;
  logic [DATA_W-1:0] curOffset;
  rejClassE          rejClassInt;

  ioWinCtrl #(
    .DATA_W(DATA_W), .WIN_AW(WIN_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT),
    .REG_LIMIT(REG_LIMIT), .UNDEF_LIMIT(UNDEF_LIMIT), .FLASH_LIMIT(FLASH_LIMIT)
  ) uCtrl (
    .clk(clk), .rst(rst), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostOffset(hostOffset), .curOffset(curOffset), .regAck(regAck),
    .dpCtl(dpCtl), .hostReady(hostReady), .regReq(regReq), .regWe(regWe),
    .rejStrobe(rejStrobe), .rejClass(rejClassInt)
  );

  ioWinData #(.DATA_W(DATA_W), .REG_AW(REG_AW)) uData (
    .clk(clk), .rst(rst), .dpCtl(dpCtl), .hostWdata(hostWdata), .regRdata(regRdata),
    .curOffset(curOffset), .hostRdata(hostRdata), .regAddr(regAddr), .regWdata(regWdata)
  );

  assign rejClass = rejClassInt;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst) (regReq && !regAck) |=> $stable(regAddr)); // R3
  AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (rst) hostReady |=> !hostReady); // R2

endmodule

// File: tb/tb_ioIndirectWindow.sv
module tb_ioIndirectWindow;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hostValid = 1'b0, hostWrite = 1'b0;
  logic [4:0]  hostOffset = '0;
  logic [31:0] hostWdata = '0;
  logic        hostReady, regReq, regWe, rejStrobe, regAck;
  logic [31:0] hostRdata, regWdata, regRdata;
  logic [16:0] regAddr;
  logic [1:0]  rejClass;

  int checks = 0, fails = 0;
  int ackLat = 1, rspCnt = 0;
  logic [31:0] mem [16];
  logic [16:0] seenAddr;
  logic        seenWe;

  always #10 clk = ~clk;

  ioIndirectWindow dut (
    .clk(clk), .rst(rst), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostOffset(hostOffset), .hostWdata(hostWdata), .hostReady(hostReady),
    .hostRdata(hostRdata), .regReq(regReq), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .regAck(regAck),
    .rejStrobe(rejStrobe), .rejClass(rejClass)
  );

  // Downstream register bus model with programmable answer latency
  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 | i;
    regAck = 1'b0; regRdata = '0; seenAddr = '0; seenWe = 1'b0;
    forever begin
      @(negedge clk);
      regAck = 1'b0;
      if (regReq) begin
        rspCnt++;
        if (rspCnt >= ackLat) begin
          regAck   = 1'b1;
          regRdata = mem[regAddr[5:2]];
          if (regWe) mem[regAddr[5:2]] = regWdata;
          seenAddr = regAddr;
          seenWe   = regWe;
          rspCnt   = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R4 watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // One host access; reports latency, request cycles, strobe with ready and one cycle later
  task automatic access(input logic wr, input logic [4:0] off, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc, output int reqCnt,
                        output logic strb, output logic [1:0] cls, output logic strbAfter);
    @(negedge clk);
    hostValid = 1'b1; hostWrite = wr; hostOffset = off; hostWdata = wd;
    cyc = 0; reqCnt = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (regReq) reqCnt++;
      if (hostReady) begin
        rd = hostRdata; strb = rejStrobe; cls = rejClass;
        hostValid = 1'b0;
        break;
      end
    end
    @(negedge clk);
    strbAfter = rejStrobe;
  endtask

  logic [31:0] rd; int cyc, rq; logic st, sa; logic [1:0] cl;

  task automatic setPtr(input logic [31:0] v);
    access(1'b1, 5'h0, v, rd, cyc, rq, st, cl, sa);
  endtask

  task automatic testReset();
    doReset();
    chk(!hostReady && !regReq && !rejStrobe, "R1 outputs idle", {hostReady, regReq, rejStrobe}, 0);
    access(1'b0, 5'h0, 0, rd, cyc, rq, st, cl, sa);
    chk(rd == 0, "R1 pointer after reset", rd, 0);
  endtask

  task automatic testPointer();
    setPtr(32'hDEAD_BEEF);
    chk(cyc == 1 && rq == 0, "R2 pointer write latency", cyc, 1);
    access(1'b0, 5'h0, 0, rd, cyc, rq, st, cl, sa);
    chk(rd == 32'hDEAD_BEEF, "R2 pointer readback", rd, 32'hDEAD_BEEF);
    chk(cyc == 1, "R2 pointer read latency", cyc, 1);
  endtask

  task automatic testForward();
    ackLat = 1;
    setPtr(32'h8);
    access(1'b0, 5'h4, 0, rd, cyc, rq, st, cl, sa);
    chk(rd == 32'hA000_0002, "R4 forwarded read data", rd, 32'hA000_0002);
    chk(seenAddr == 17'h8 && !seenWe, "R3 read addr/dir", seenAddr, 17'h8);
    chk(cyc == 2 && rq == 1, "R4 one-cycle bus latency", cyc, 2);
    access(1'b1, 5'h4, 32'h1234_5678, rd, cyc, rq, st, cl, sa);
    chk(seenWe && mem[2] == 32'h1234_5678, "R3 forwarded write", mem[2], 32'h1234_5678);
    chk(!st, "R3 no strobe when forwarded", st, 0);
  endtask

  task automatic testStall();
    ackLat = 4;
    setPtr(32'hC);
    access(1'b0, 5'h4, 0, rd, cyc, rq, st, cl, sa);
    chk(cyc == 5, "R4 stall until ack", cyc, 5);
    chk(rq == 4, "R4 request cycles", rq, 4);
    chk(rd == 32'hA000_0003, "R4 stalled read data", rd, 32'hA000_0003);
    ackLat = 1;
  endtask

  task automatic rejectOne(input logic [31:0] ptr, input logic [1:0] expCls, input string tag);
    setPtr(ptr);
    access(1'b0, 5'h4, 0, rd, cyc, rq, st, cl, sa);
    chk(rd == 0 && rq == 0 && cyc == 1, {tag, " read rejected"}, rd, 0);
    chk(st && cl == expCls, {tag, " class"}, cl, expCls);
    chk(!sa, "R10 strobe one cycle", sa, 0);
    access(1'b1, 5'h4, 32'h5555_AAAA, rd, cyc, rq, st, cl, sa);
    chk(rq == 0 && st && cl == expCls, {tag, " write dropped"}, rq, 0);
  endtask

  task automatic testRegions();
    rejectOne(32'h0001_FFFF, 2'd1, "R9 R5 undef low edge");
    rejectOne(32'h0007_FFFE, 2'd1, "R5 undef high edge");
    rejectOne(32'h0007_FFFF, 2'd2, "R6 flash low edge");
    rejectOne(32'h000F_FFFE, 2'd2, "R6 flash high edge");
    rejectOne(32'h000F_FFFF, 2'd3, "R7 unknown low edge");
    rejectOne(32'hFFFF_FFFF, 2'd3, "R7 unknown all ones");
  endtask

  task automatic testBoundary();
    setPtr(32'h0001_FFFE);
    access(1'b0, 5'h4, 0, rd, cyc, rq, st, cl, sa);
    chk(rq == 1 && seenAddr == 17'h1FFFE && !st, "R9 last register offset forwarded", seenAddr, 17'h1FFFE);
    chk(rd == mem[15], "R9 last register read data", rd, mem[15]);
  endtask

  task automatic testOtherOffsets();
    setPtr(32'h40);
    for (int k = 0; k < 2; k++) begin
      logic [4:0] o;
      o = (k == 0) ? 5'h08 : 5'h1C;
      access(1'b1, o, 32'hDEAD_0000, rd, cyc, rq, st, cl, sa);
      chk(rq == 0 && !st && cyc == 1, "R8 unused offset write ignored", rq, 0);
      access(1'b0, o, 0, rd, cyc, rq, st, cl, sa);
      chk(rd == 0 && !st, "R8 unused offset reads zero", rd, 0);
      access(1'b0, 5'h0, 0, rd, cyc, rq, st, cl, sa);
      chk(rd == 32'h40, "R8 pointer untouched", rd, 32'h40);
    end
  endtask

  task automatic testResetTarget();
    setPtr(32'h24);
    doReset();
    access(1'b0, 5'h4, 0, rd, cyc, rq, st, cl, sa);
    chk(rq == 1 && seenAddr == 0, "R11 target zero after reset", seenAddr, 0);
    chk(rd == mem[0], "R11 read of register 0", rd, mem[0]);
  endtask

  initial begin
    testReset();
    testPointer();
    testForward();
    testStall();
    testRegions();
    testBoundary();
    testOtherOffsets();
    testResetTarget();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule